// File: doc/BRIEF.md
# Serial SAR Converter Readout Controller

This block is the host-side master for a 10-bit successive-approximation converter that sits on a three-wire serial link. The three wires are an active-low chip select, a serial clock and a data line back from the converter. A start request pulls chip select low, and the falling edge of chip select makes the converter take a sample and begin converting. The controller then keeps the serial clock parked low. It watches the data line on every system clock until the converter raises it to announce that the conversion is finished. Only then does it generate serial clock pulses, and it gathers the unipolar straight-binary result most significant bit first.

The serial clock comes from the system clock through a run-time divider. Each half period lasts `clkDiv+1` system cycles. The divider lets software keep the link below the converter's 2.1 MHz ceiling; at 50 MHz that means `clkDiv` of 11 or more. The converter changes its data line on the falling clock edge, so the controller samples on the rising edge.

When the frame ends, the controller raises chip select and issues a one-cycle valid pulse with the result. It then holds chip select high for a programmable settle time so the converter can track its next sample. A watchdog on the end-of-conversion wait aborts a frame whose high bit never arrives. In that case the block raises a one-cycle error flag.

Top module: `sar_link_ctrl`

## Requirements
- R1: When `startReq` is high while the block is idle, `adcCsN` is low and `busy` is high from the next clock cycle on.
- R2: `adcSclk` stays low whenever `adcCsN` is high and throughout the end-of-conversion wait. While `adcCsN` is high, the level on `adcDout` starts no frame and produces no clock pulse.
- R3: After `adcDout` is seen high during the wait, the block produces exactly DATA_W+1 rising edges on `adcSclk` and samples `adcDout` at each one. The first sample is the end-of-conversion bit and is dropped. The remaining DATA_W samples form `result`, with the first of them as bit DATA_W-1.
- R4: Every high phase and every low phase of `adcSclk` inside a frame lasts exactly `clkDiv+1` system clock cycles.
- R5: `resultValid` is a single-cycle pulse. It is high in the first cycle after `adcCsN` returns high at the end of a successful frame. `result` holds its value until the next successful frame.
- R6: If `adcDout` stays low for `tmoLimit` wait cycles (a value of 0 counts as 1), `adcCsN` rises after exactly that many low cycles. `timeoutErr` then pulses for one cycle, `resultValid` stays low and no `adcSclk` edge occurs.
- R7: After any frame ends, `adcCsN` stays high for at least `gapCycles+2` cycles. With `startReq` held high it stays high for exactly that long.
- R8: A `startReq` that arrives while `busy` is high, including the settle time, is ignored and not queued.
- R9: During reset `adcCsN` is 1, `adcSclk` is 0, and `busy`, `resultValid`, `timeoutErr` and `result` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Request one conversion frame |
| clkDiv | input | DIV_W | Serial clock half period minus one, in system cycles |
| tmoLimit | input | TMO_W | Maximum end-of-conversion wait in system cycles |
| gapCycles | input | GAP_W | Extra chip-select-high settle cycles after a frame |
| adcDout | input | 1 | Serial data from the converter |
| adcCsN | output | 1 | Active-low chip select to the converter |
| adcSclk | output | 1 | Serial clock to the converter |
| busy | output | 1 | Frame or settle time in progress |
| result | output | DATA_W | Last converted value |
| resultValid | output | 1 | One-cycle strobe when a new result is ready |
| timeoutErr | output | 1 | One-cycle strobe when the wait timed out |

## Verification
A miscount in the bit counter or divider phase shows up within one frame. The number of clock pulses or the width of a high phase comes out wrong, and the assembled word shifts by a bit. This is caught by comparing every possible 10-bit code against the word the converter model sent. A wrong wait or settle counter shows at the next chip-select edge as a low or high interval whose length differs from `tmoLimit` or `gapCycles+2`. A state machine that leaks a start through settle time, or reacts to the floating data line, shows as an extra chip-select fall within a few dozen cycles of an idle window.

// File: rtl/sar_link_pkg.sv
package sar_link_pkg;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_WAIT_EOC = 2'd1,
    ST_SHIFT    = 2'd2,
    ST_GAP      = 2'd3
  } linkState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clearCnt;
    logic countUp;
    logic runSclk;
    logic captureResult;
  } dpStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic tmoHit;
    logic gapDone;
    logic frameDone;
  } dpStatus_t;

endpackage

// File: rtl/sar_link_dp.sv
module sar_link_dp
  import sar_link_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int DIV_W  = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DIV_W-1:0]  clkDiv,
  input  logic [CNT_W-1:0]  tmoLimit,
  input  logic [CNT_W-1:0]  gapCycles,
  input  logic              adcDout,
  output logic              sclk,
  output logic [DATA_W-1:0] result,
  output dpStatus_t         status
);

  // one leading pulse clocks past the end-of-conversion bit
  localparam int FRAME = DATA_W + 1;
  localparam int BIT_W = $clog2(FRAME + 1);

  logic [DIV_W-1:0]  phase;
  logic [BIT_W-1:0]  bitCnt;
  logic [DATA_W-1:0] shiftReg;
  logic [CNT_W-1:0]  timer;
  logic [CNT_W:0]    timerNext;
  logic              wrap;

  assign wrap = strobe.runSclk && (phase >= clkDiv);

  // serial clock generator and input shifter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= '0;
      sclk     <= 1'b0;
      bitCnt   <= '0;
      shiftReg <= '0;
    end else if (!strobe.runSclk) begin
      phase  <= '0;
      sclk   <= 1'b0;
      bitCnt <= '0;
    end else if (wrap) begin
      phase <= '0;
      sclk  <= !sclk;
      if (!sclk) begin
        shiftReg <= {shiftReg[DATA_W-2:0], adcDout};
        bitCnt   <= bitCnt + 1'b1;
      end
    end else begin
      phase <= phase + 1'b1;
    end
  end

  // shared wait / settle timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                timer <= '0;
    else if (strobe.clearCnt) timer <= '0;
    else if (strobe.countUp)  timer <= timer + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     result <= '0;
    else if (strobe.captureResult) result <= shiftReg;
  end

  assign timerNext        = {1'b0, timer} + 1'b1;
  assign status.tmoHit    = timerNext >= {1'b0, tmoLimit};
  assign status.gapDone   = timer >= gapCycles;
  assign status.frameDone = wrap && sclk && (bitCnt == BIT_W'(FRAME));

  // R2: clock parked low whenever the shifter is not running
  p_sclk_parked_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.runSclk |-> !sclk);

  // R3: never more rising edges than one frame
  p_edge_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= BIT_W'(FRAME));

  // R3: a rising edge captures the line level seen at that edge
  p_capture_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrap && !sclk) |=> (shiftReg[0] == $past(adcDout)));

  // R4: clock holds its level until the divider wraps
  p_half_period_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.runSclk && !wrap) |=> $stable(sclk));

endmodule

// File: rtl/sar_link_fsm.sv
module sar_link_fsm
  import sar_link_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  input  logic      adcDout,
  input  dpStatus_t status,
  output dpStrobe_t strobe,
  output logic      csN,
  output logic      busy,
  output logic      resultValid,
  output logic      timeoutErr
);

  linkState_t state, nextState;
  logic       validSet, errSet;

  always_comb begin
    nextState = state;
    strobe    = '0;
    validSet  = 1'b0;
    errSet    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          nextState       = ST_WAIT_EOC;
          strobe.clearCnt = 1'b1;
        end
      end
      ST_WAIT_EOC: begin
        strobe.countUp = 1'b1;
        if (adcDout) begin
          nextState       = ST_SHIFT;
          strobe.clearCnt = 1'b1;
        end else if (status.tmoHit) begin
          nextState       = ST_GAP;
          strobe.clearCnt = 1'b1;
          errSet          = 1'b1;
        end
      end
      ST_SHIFT: begin
        strobe.runSclk = 1'b1;
        if (status.frameDone) begin
          nextState            = ST_GAP;
          strobe.captureResult = 1'b1;
          strobe.clearCnt      = 1'b1;
          validSet             = 1'b1;
        end
      end
      ST_GAP: begin
        strobe.countUp = 1'b1;
        if (status.gapDone) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      csN         <= 1'b1;
      resultValid <= 1'b0;
      timeoutErr  <= 1'b0;
    end else begin
      state       <= nextState;
      csN         <= (nextState == ST_IDLE) || (nextState == ST_GAP);
      resultValid <= validSet;
      timeoutErr  <= errSet;
    end
  end

  assign busy = (state != ST_IDLE);

  // R1: an accepted start drops chip select on the next cycle
  p_start_takes_cs_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && startReq) |=> (!csN && busy));

  // R5: valid is a single pulse with chip select already high
  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);
  p_valid_cs_high_r5: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> csN);

  // R6: error is a single pulse, exclusive with valid
  p_err_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    timeoutErr |=> !timeoutErr);
  p_err_alone_r6: assert property (@(posedge clk) disable iff (!rstN)
    timeoutErr |-> (csN && !resultValid));

  // R7 / R8: settle time never hands chip select straight back low
  p_gap_holds_cs_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_GAP) |=> csN);

endmodule

// File: rtl/sar_link_ctrl.sv
module sar_link_ctrl
  import sar_link_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int DIV_W  = 8,
  parameter int TMO_W  = 16,
  parameter int GAP_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [DIV_W-1:0]  clkDiv,
  input  logic [TMO_W-1:0]  tmoLimit,
  input  logic [GAP_W-1:0]  gapCycles,
  input  logic              adcDout,
  output logic              adcCsN,
  output logic              adcSclk,
  output logic              busy,
  output logic [DATA_W-1:0] result,
  output logic              resultValid,
  output logic              timeoutErr
);

  localparam int CNT_W = (TMO_W > GAP_W) ? TMO_W : GAP_W;

  dpStrobe_t dpStrobe;
  dpStatus_t dpStatus;

  sar_link_fsm u_fsm (
    .clk         (clk),
    .rstN        (rstN),
    .startReq    (startReq),
    .adcDout     (adcDout),
    .status      (dpStatus),
    .strobe      (dpStrobe),
    .csN         (adcCsN),
    .busy        (busy),
    .resultValid (resultValid),
    .timeoutErr  (timeoutErr)
  );

  sar_link_dp #(
    .DATA_W (DATA_W),
    .DIV_W  (DIV_W),
    .CNT_W  (CNT_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (dpStrobe),
    .clkDiv    (clkDiv),
    .tmoLimit  (CNT_W'(tmoLimit)),
    .gapCycles (CNT_W'(gapCycles)),
    .adcDout   (adcDout),
    .sclk      (adcSclk),
    .result    (result),
    .status    (dpStatus)
  );

  // R2: no serial clock while deselected
  p_no_clk_deselected_r2: assert property (@(posedge clk) disable iff (!rstN)
    adcCsN |-> !adcSclk);

endmodule

// File: tb/sim_sar_link_ctrl.sv
module sim_sar_link_ctrl;
  localparam int DATA_W = 10;
  localparam int DIV_W  = 8;
  localparam int TMO_W  = 16;
  localparam int GAP_W  = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic [DIV_W-1:0] clkDiv = '0;
  logic [TMO_W-1:0] tmoLimit = 16'd100;
  logic [GAP_W-1:0] gapCycles = 8'd2;
  logic adcDout;
  logic adcCsN, adcSclk, busy, resultValid, timeoutErr;
  logic [DATA_W-1:0] result;

  int total = 0;
  int bad = 0;
  int validSeen = 0;

  always #10 clk = ~clk;

  sar_link_ctrl #(.DATA_W(DATA_W), .DIV_W(DIV_W), .TMO_W(TMO_W), .GAP_W(GAP_W)) u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .clkDiv(clkDiv),
    .tmoLimit(tmoLimit), .gapCycles(gapCycles), .adcDout(adcDout),
    .adcCsN(adcCsN), .adcSclk(adcSclk), .busy(busy), .result(result),
    .resultValid(resultValid), .timeoutErr(timeoutErr)
  );

  // converter model: high bit after a delay, then data changes on falling clock
  logic [DATA_W-1:0] modelWord = '0;
  int convDelay = 20;
  int convCnt = 0;
  logic eocFlag = 1'b0;
  int bitIdx = 0;
  logic modelOut;

  always @(posedge clk) begin
    if (adcCsN) begin
      convCnt <= 0;
      eocFlag <= 1'b0;
    end else if (convCnt >= convDelay) eocFlag <= 1'b1;
    else convCnt <= convCnt + 1;
  end

  always @(negedge adcSclk or posedge adcCsN) begin
    if (adcCsN) bitIdx <= 0;
    else bitIdx <= bitIdx + 1;
  end

  always_comb begin
    if (bitIdx == 0) modelOut = eocFlag;
    else if (bitIdx <= DATA_W) modelOut = modelWord[DATA_W - bitIdx];
    else modelOut = 1'b0;
  end

  // line floats (seen as high) while deselected
  assign adcDout = adcCsN ? 1'b1 : modelOut;

  always @(negedge clk) if (resultValid) validSeen++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runTxn(input logic [DATA_W-1:0] w, input int div, input int tmo,
                        input int conv, input bit expTmo);
    int lows = 0;
    int rises = 0;
    int vcnt = 0;
    int ecnt = 0;
    int hiRun = 0;
    int badHi = 0;
    int parkBad = 0;
    int guard = 0;
    int expLows;
    logic prev = 1'b0;
    logic [DATA_W-1:0] got = '0;
    modelWord = w;
    convDelay = conv;
    clkDiv    = DIV_W'(div);
    tmoLimit  = TMO_W'(tmo);
    startReq  = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    chk(!adcCsN && busy, "R1 cs low and busy after start", int'({adcCsN, busy}), 1);
    while (busy && guard < 20000) begin
      guard++;
      if (!adcCsN) lows++;
      if (adcCsN && adcSclk) parkBad++;
      if (adcSclk && !prev) rises++;
      if (adcSclk) hiRun++;
      else begin
        if (prev && hiRun != div + 1) badHi++;
        hiRun = 0;
      end
      if (resultValid) begin
        vcnt++;
        got = result;
      end
      if (timeoutErr) ecnt++;
      prev = adcSclk;
      @(negedge clk);
    end
    chk(parkBad == 0, "R2 sclk low while cs high", parkBad, 0);
    if (expTmo) begin
      expLows = (tmo == 0) ? 1 : tmo;
      chk(lows == expLows, "R6 cs low cycles on timeout", lows, expLows);
      chk(ecnt == 1, "R6 timeoutErr pulses", ecnt, 1);
      chk(vcnt == 0, "R6 no resultValid on timeout", vcnt, 0);
      chk(rises == 0, "R2 no sclk during wait", rises, 0);
    end else begin
      chk(got == w, "R3 result word", int'(got), int'(w));
      chk(rises == DATA_W + 1, "R3 sclk rising edges", rises, DATA_W + 1);
      chk(badHi == 0, "R4 sclk high phase width", badHi, 0);
      chk(vcnt == 1, "R5 resultValid pulses", vcnt, 1);
      chk(ecnt == 0, "R6 no error on good frame", ecnt, 0);
      chk(result == w, "R5 result held after frame", int'(result), int'(w));
    end
  endtask

  task automatic gapTest(input int g);
    int n = 0;
    int guard = 0;
    gapCycles = GAP_W'(g);
    clkDiv    = '0;
    tmoLimit  = 16'd100;
    convDelay = 10;
    modelWord = 10'h2A5;
    startReq  = 1'b1;
    while (!resultValid && guard < 5000) begin
      guard++;
      @(negedge clk);
    end
    while (adcCsN && guard < 10000) begin
      guard++;
      n++;
      @(negedge clk);
    end
    startReq = 1'b0;
    chk(n == g + 2, "R7 cs high between back-to-back frames", n, g + 2);
    while (busy && guard < 20000) begin
      guard++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v0;
    int guard;
    int stray;
    repeat (3) @(negedge clk);
    // R9: reset values
    chk(adcCsN == 1'b1 && adcSclk == 1'b0, "R9 reset cs/sclk", int'({adcCsN, adcSclk}), 2);
    chk(!busy && !resultValid && !timeoutErr && result == '0, "R9 reset status",
        int'({busy, resultValid, timeoutErr}), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2: floating-high line while deselected starts nothing
    stray = 0;
    repeat (20) begin
      @(negedge clk);
      if (!adcCsN || adcSclk || busy) stray++;
    end
    chk(stray == 0, "R2 idle ignores data line", stray, 0);

    // R3 R4 R5: every code at the fastest divider
    for (int w = 0; w < (1 << DATA_W); w++)
      runTxn(DATA_W'(w), 0, 100, 20, 1'b0);

    // R4: slower dividers
    for (int d = 1; d <= 3; d++)
      for (int k = 0; k < 32; k++)
        runTxn(DATA_W'((k * 37) ^ (d << 7)), d, 300, 30, 1'b0);

    // R6: timeout lengths including the zero corner
    runTxn('0, 0, 0, 1000000, 1'b1);
    runTxn('0, 0, 1, 1000000, 1'b1);
    runTxn('0, 0, 2, 1000000, 1'b1);
    runTxn('0, 0, 17, 1000000, 1'b1);
    runTxn(10'h3FF, 0, 100, 20, 1'b0);

    // R7: settle time sweep
    gapTest(0);
    gapTest(1);
    gapTest(5);
    gapTest(9);

    // R8: starts while busy are dropped
    gapCycles = 8'd10;
    clkDiv    = 8'd1;
    tmoLimit  = 16'd100;
    convDelay = 15;
    modelWord = 10'h155;
    v0 = validSeen;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    repeat (25) @(negedge clk);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    guard = 0;
    while (!resultValid && guard < 5000) begin
      guard++;
      @(negedge clk);
    end
    @(negedge clk);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    guard = 0;
    while (busy && guard < 5000) begin
      guard++;
      @(negedge clk);
    end
    stray = 0;
    repeat (40) begin
      @(negedge clk);
      if (!adcCsN || busy) stray++;
    end
    chk(stray == 0, "R8 start during busy not queued", stray, 0);
    chk(validSeen - v0 == 1, "R8 single frame for repeated start", validSeen - v0, 1);
    chk(result == 10'h155, "R3 result after ignored starts", int'(result), 'h155);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule